// File: doc/BRIEF.md
# Two-Thread Partitioned Way Replacement

This block chooses the victim way when a miss arrives at one set of an N-way set-associative cache that two hardware threads share. It keeps a per-thread occupancy limit, so neither thread can take every way of a set. A reservation degree Y holds back Y ways of each set for the other thread. A requester may therefore own at most N minus Y valid lines in a set. Lines beyond both reservations move between the threads on demand. The limit is enforced only when a victim is chosen: the choice looks at each way's valid bit, owner-thread bit and recency rank. No separate bookkeeping is kept.

The set state is held inside the block as a small register array, one entry per set, so the policy can be driven on its own. A request names a set, a thread and either a hit (which refreshes recency) or a miss (which fills a way). One cycle later the block reports the chosen way, whether a valid line was displaced and who owned it, and the set's valid and owner bits after the update. When a single-thread flag is raised the limit is lifted and the requester may use every way. Setting Y to N/2 gives a fixed, non-overlapping half-and-half split.

Top module: `pwr_repl_top`

## Requirements
- R1: A request accepted at a clock edge produces `resp_valid` high after that same edge, and the set outputs then show the state after the update. A miss sets the chosen way's valid bit and writes the requester's thread ID into its owner bit.
- R2: The effective reservation degree is the smaller of `resv_deg` and WAYS/2. When `solo_mode` is high the requester's cap is WAYS; otherwise it is WAYS minus the effective degree.
- R3: On a miss, if the requester owns fewer valid lines in the set than its cap and the set has an invalid way, the lowest-numbered invalid way is filled and `resp_evict` is 0.
- R4: On a miss below the cap with no invalid way, the victim is the least recently used way among the requester's own lines and the other thread's lines. The other thread's lines count only while that thread holds more than the effective degree. `resp_evict` is 1.
- R5: On a miss when the requester already holds its cap or more, the victim is the least recently used of its own lines, even when invalid ways remain.
- R6: A thread's line count never rises on a miss once it is at its cap. Starting from reset with a fixed configuration, no thread ever holds more than its cap in any set.
- R7: With the effective degree equal to WAYS/2 and `solo_mode` low, a miss never displaces a line owned by the other thread.
- R8: Recency is a strict ranking per set. After reset, way 0 is most recent and way WAYS-1 is least recent. A fill, or a hit on a valid way, makes that way the most recent, and every way that was more recent moves back one place.
- R9: A hit request changes no valid or owner bit. `resp_hit` is 1, `resp_way` echoes the requested way and `resp_evict` is 0. A hit on an invalid way changes no state at all, including recency.
- R10: In single-thread mode a miss with no invalid way evicts the least recently used valid way of the set, whoever owns it.
- R11: After reset every way of every set is invalid with owner 0, and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_hit | input | 1 | 1 = hit (recency refresh), 0 = miss (fill) |
| req_tid | input | 1 | Requesting thread (0 or 1) |
| req_set | input | $clog2(SETS) | Set index |
| req_way | input | $clog2(WAYS) | Way that hit (ignored on a miss) |
| resv_deg | input | $clog2(WAYS+1) | Reservation degree Y |
| solo_mode | input | 1 | Single-thread mode: cap lifted |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_hit | output | 1 | Response belongs to a hit |
| resp_way | output | $clog2(WAYS) | Filled way (miss) or refreshed way (hit) |
| resp_evict | output | 1 | A valid line was displaced |
| resp_victim_tid | output | 1 | Owner of the displaced line (0 when none) |
| set_valid_o | output | WAYS | Valid bits of the addressed set after update |
| set_owner_o | output | WAYS | Owner bits of the addressed set after update |

## Verification
The bench builds the block with its default 8 ways and 4 sets. With those values, every reservation degree from 0 to 4 can be reached, and a value of 9 exercises the clamp. Four sets give interleaved traffic enough room to reach full sets, at-cap requesters and cross-thread borrowing within a few hundred requests per phase. Each phase starts from reset with a fixed degree or with single-thread mode on, so the occupancy cap and the half-split case are checked across whole random runs.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  // Effective reservation: never more than half the ways.
  function automatic int unsigned clamp_resv(int unsigned deg, int unsigned ways);
    return (deg > ways / 2) ? ways / 2 : deg;
  endfunction

  // Lines one thread may hold in a set.
  function automatic int unsigned thread_cap(int unsigned yeff, int unsigned ways, logic solo);
    return solo ? ways : ways - yeff;
  endfunction

endpackage

// File: rtl/pwr_age_touch.sv
module pwr_age_touch #(
  parameter  int WAYS = 8,
  localparam int AW   = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][AW-1:0] ages_i,
  input  logic [AW-1:0]           touch,
  output logic [WAYS-1:0][AW-1:0] ages_o
);

  logic [AW-1:0] touched_age;
  assign touched_age = ages_i[touch];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_comb begin
      if (touch == AW'(g))
        ages_o[g] = '0;
      else if (ages_i[g] < touched_age)
        ages_o[g] = ages_i[g] + AW'(1);
      else
        ages_o[g] = ages_i[g];
    end
  end

endmodule

// File: rtl/pwr_set_store.sv
module pwr_set_store #(
  parameter  int WAYS = 8,
  parameter  int SETS = 4,
  localparam int AW   = $clog2(WAYS),
  localparam int SW   = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SW-1:0]           rd_set,
  output logic [WAYS-1:0]         rd_valid,
  output logic [WAYS-1:0]         rd_owner,
  output logic [WAYS-1:0][AW-1:0] rd_age,
  input  logic                    wr_en,
  input  logic [SW-1:0]           wr_set,
  input  logic [WAYS-1:0]         wr_valid,
  input  logic [WAYS-1:0]         wr_owner,
  input  logic [WAYS-1:0][AW-1:0] wr_age
);

  function automatic logic [WAYS-1:0][AW-1:0] init_ages();
    logic [WAYS-1:0][AW-1:0] a;
    for (int i = 0; i < WAYS; i++) a[i] = AW'(i);
    return a;
  endfunction

  logic [WAYS-1:0]         valid_q [SETS];
  logic [WAYS-1:0]         owner_q [SETS];
  logic [WAYS-1:0][AW-1:0] age_q   [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= '0;
        owner_q[s] <= '0;
        age_q[s]   <= init_ages();
      end else if (wr_en && wr_set == SW'(s)) begin
        valid_q[s] <= wr_valid;
        owner_q[s] <= wr_owner;
        age_q[s]   <= wr_age;
      end
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_owner = owner_q[rd_set];
  assign rd_age   = age_q[rd_set];

endmodule

// File: rtl/pwr_victim_pick.sv
module pwr_victim_pick
  import pwr_pkg::*;
#(
  parameter  int WAYS = 8,
  localparam int AW   = $clog2(WAYS),
  localparam int CW   = $clog2(WAYS + 1)
) (
  input  logic [WAYS-1:0]         way_valid,
  input  logic [WAYS-1:0]         way_owner,
  input  logic [WAYS-1:0][AW-1:0] way_age,
  input  logic                    req_tid,
  input  logic [CW-1:0]           yeff,
  input  logic                    solo,
  output logic [AW-1:0]           vic_way,
  output logic                    vic_valid,
  output logic                    vic_owner,
  output logic [CW-1:0]           own_cnt,
  output logic [CW-1:0]           oth_cnt,
  output logic                    at_cap,
  output logic                    any_free
);

  function automatic logic [CW-1:0] popc(logic [WAYS-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < WAYS; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  function automatic logic [AW-1:0] first_free(logic [WAYS-1:0] v);
    logic [AW-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (!v[i]) r = AW'(i);
    return r;
  endfunction

  function automatic logic [AW-1:0] oldest(logic [WAYS-1:0] cand,
                                           logic [WAYS-1:0][AW-1:0] ages);
    logic [AW-1:0] best, best_age;
    logic          found;
    best = '0; best_age = '0; found = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (cand[i] && (!found || ages[i] > best_age)) begin
        best     = AW'(i);
        best_age = ages[i];
        found    = 1'b1;
      end
    end
    return best;
  endfunction

  logic [WAYS-1:0] own_mask, oth_mask, cand;
  logic [CW-1:0]   cap_w;
  logic            share_ok;

  always_comb begin
    own_mask = way_valid & ~(way_owner ^ {WAYS{req_tid}});
    oth_mask = way_valid & ~own_mask;
    own_cnt  = popc(own_mask);
    oth_cnt  = popc(oth_mask);
    cap_w    = CW'(thread_cap(int'(yeff), WAYS, solo));
    at_cap   = own_cnt >= cap_w;
    any_free = ~&way_valid;
    share_ok = solo || (oth_cnt > yeff);
    cand     = at_cap ? own_mask : (own_mask | (share_ok ? oth_mask : '0));
    if (!at_cap && any_free)
      vic_way = first_free(way_valid);
    else
      vic_way = oldest(cand, way_age);
    vic_valid = way_valid[vic_way];
    vic_owner = way_owner[vic_way];
  end

endmodule

// File: rtl/pwr_repl_top.sv
module pwr_repl_top
  import pwr_pkg::*;
#(
  parameter  int WAYS = 8,
  parameter  int SETS = 4,
  localparam int AW   = $clog2(WAYS),
  localparam int CW   = $clog2(WAYS + 1),
  localparam int SW   = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_hit,
  input  logic            req_tid,
  input  logic [SW-1:0]   req_set,
  input  logic [AW-1:0]   req_way,
  input  logic [CW-1:0]   resv_deg,
  input  logic            solo_mode,
  output logic            resp_valid,
  output logic            resp_hit,
  output logic [AW-1:0]   resp_way,
  output logic            resp_evict,
  output logic            resp_victim_tid,
  output logic [WAYS-1:0] set_valid_o,
  output logic [WAYS-1:0] set_owner_o
);

  logic [WAYS-1:0]         cur_valid, cur_owner;
  logic [WAYS-1:0][AW-1:0] cur_age, new_age;
  logic [CW-1:0]           yeff, own_cnt, oth_cnt;
  logic [AW-1:0]           vic_way, touch_way;
  logic                    vic_valid, vic_owner, at_cap, any_free;
  logic                    miss_fire, hit_fire, wr_en;
  logic [WAYS-1:0]         way_wr_oh, next_valid, next_owner;

  assign yeff = CW'(clamp_resv(int'(resv_deg), WAYS));

  pwr_set_store #(.WAYS(WAYS), .SETS(SETS)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (req_set),
    .rd_valid (cur_valid),
    .rd_owner (cur_owner),
    .rd_age   (cur_age),
    .wr_en    (wr_en),
    .wr_set   (req_set),
    .wr_valid (next_valid),
    .wr_owner (next_owner),
    .wr_age   (new_age)
  );

  pwr_victim_pick #(.WAYS(WAYS)) i_pick (
    .way_valid (cur_valid),
    .way_owner (cur_owner),
    .way_age   (cur_age),
    .req_tid   (req_tid),
    .yeff      (yeff),
    .solo      (solo_mode),
    .vic_way   (vic_way),
    .vic_valid (vic_valid),
    .vic_owner (vic_owner),
    .own_cnt   (own_cnt),
    .oth_cnt   (oth_cnt),
    .at_cap    (at_cap),
    .any_free  (any_free)
  );

  pwr_age_touch #(.WAYS(WAYS)) i_age (
    .ages_i (cur_age),
    .touch  (touch_way),
    .ages_o (new_age)
  );

  always_comb begin
    miss_fire  = req_valid && !req_hit;
    hit_fire   = req_valid && req_hit && cur_valid[req_way];
    wr_en      = miss_fire || hit_fire;
    touch_way  = miss_fire ? vic_way : req_way;
    way_wr_oh  = miss_fire ? (WAYS'(1) << vic_way) : '0;
    next_valid = cur_valid | way_wr_oh;
    next_owner = (cur_owner & ~way_wr_oh) | (way_wr_oh & {WAYS{req_tid}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid      <= 1'b0;
      resp_hit        <= 1'b0;
      resp_way        <= '0;
      resp_evict      <= 1'b0;
      resp_victim_tid <= 1'b0;
      set_valid_o     <= '0;
      set_owner_o     <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_hit        <= req_hit;
        resp_way        <= touch_way;
        resp_evict      <= miss_fire && vic_valid;
        resp_victim_tid <= miss_fire && vic_valid && vic_owner;
        set_valid_o     <= next_valid;
        set_owner_o     <= next_owner;
      end
    end
  end

endmodule

// File: rtl/pwr_repl_chk.sv
module pwr_repl_chk #(
  parameter  int WAYS = 8,
  localparam int CW   = $clog2(WAYS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_tid,
  input logic            solo_mode,
  input logic            miss_fire,
  input logic            at_cap,
  input logic            any_free,
  input logic            vic_valid,
  input logic            vic_owner,
  input logic [CW-1:0]   own_cnt,
  input logic [CW-1:0]   oth_cnt,
  input logic [CW-1:0]   yeff,
  input logic [WAYS-1:0] way_wr_oh,
  input logic            resp_valid,
  input logic            resp_evict,
  input logic            resp_victim_tid,
  input logic [WAYS-1:0] set_valid_o,
  input logic [WAYS-1:0] set_owner_o
);

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R1

  AST_FILL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_wr_oh)); // R1

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire && !at_cap && any_free |=> !resp_evict); // R3

  AST_SHARE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire && vic_valid && (vic_owner != req_tid) |-> solo_mode || (oth_cnt > yeff)); // R4

  AST_CAP_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire && at_cap |=> resp_evict && (resp_victim_tid == $past(req_tid))); // R5

  AST_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire && at_cap |=>
      $countones(set_valid_o & ~(set_owner_o ^ {WAYS{$past(req_tid)}})) == $past(own_cnt)); // R6

  AST_HALF_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire && !solo_mode && (yeff == CW'(WAYS / 2)) && vic_valid |-> vic_owner == req_tid); // R7

endmodule

bind pwr_repl_top pwr_repl_chk #(.WAYS(WAYS)) i_chk (.*);

// File: tb/test_pwr_repl_top.sv
module test_pwr_repl_top;
  localparam int WAYS = 8;
  localparam int SETS = 4;
  localparam int AW   = 3;
  localparam int CW   = 4;
  localparam int SW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_hit = 1'b0, req_tid = 1'b0;
  logic [SW-1:0]   req_set = '0;
  logic [AW-1:0]   req_way = '0;
  logic [CW-1:0]   resv_deg = '0;
  logic            solo_mode = 1'b0;
  logic            resp_valid, resp_hit, resp_evict, resp_victim_tid;
  logic [AW-1:0]   resp_way;
  logic [WAYS-1:0] set_valid_o, set_owner_o;

  always #2 clk = ~clk;

  pwr_repl_top #(.WAYS(WAYS), .SETS(SETS)) i_pwr_repl_top (.*);

  int  n_chk = 0, n_fail = 0;
  bit  mv [SETS][WAYS];
  bit  mo [SETS][WAYS];
  int  ma [SETS][WAYS];

  task automatic chk(bit ok, string tag, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mv[s][w] = 0; mo[s][w] = 0; ma[s][w] = w;
      end
  endtask

  function automatic int cnt(int s, bit t);
    int n = 0;
    for (int w = 0; w < WAYS; w++) if (mv[s][w] && mo[s][w] == t) n++;
    return n;
  endfunction

  function automatic int lru_pick(int s, bit t, bit take_other);
    int best = -1;
    for (int w = 0; w < WAYS; w++)
      if (mv[s][w] && (mo[s][w] == t || take_other))
        if (best < 0 || ma[s][w] > ma[s][best]) best = w;
    return best;
  endfunction

  task automatic touch(int s, int w);
    int a = ma[s][w];
    for (int i = 0; i < WAYS; i++) if (ma[s][i] < a) ma[s][i]++;
    ma[s][w] = 0;
  endtask

  task automatic do_req(bit hit, bit tid, int s, int w);
    int yeff, cap, own, oth, ew, free_w;
    bit ev, evt;
    string tag;
    logic [WAYS-1:0] xv, xo;
    @(negedge clk);
    req_valid = 1; req_hit = hit; req_tid = tid;
    req_set = SW'(s); req_way = AW'(w);
    @(posedge clk); #1;
    req_valid = 0;
    yeff = (int'(resv_deg) > WAYS / 2) ? WAYS / 2 : int'(resv_deg);
    cap  = solo_mode ? WAYS : WAYS - yeff;
    own  = cnt(s, tid);
    oth  = cnt(s, !tid);
    free_w = -1;
    for (int i = WAYS - 1; i >= 0; i--) if (!mv[s][i]) free_w = i;
    ev = 0; evt = 0;
    if (hit) begin
      ew = w; tag = "R9";
      if (mv[s][w]) touch(s, w);
    end else begin
      if (own < cap && free_w >= 0) begin
        ew = free_w; tag = "R3";
      end else if (own < cap) begin
        ew = lru_pick(s, tid, solo_mode || oth > yeff);
        tag = solo_mode ? "R10" : "R4";
      end else begin
        ew = lru_pick(s, tid, 0); tag = "R5";
      end
      ev = mv[s][ew]; evt = ev && mo[s][ew];
      mv[s][ew] = 1; mo[s][ew] = tid;
      touch(s, ew);
    end
    for (int i = 0; i < WAYS; i++) begin xv[i] = mv[s][i]; xo[i] = mo[s][i]; end
    chk(resp_valid === 1'b1 && resp_hit === hit, "R1 resp_valid/resp_hit", int'(resp_valid), 1);
    chk(int'(resp_way) == ew, {tag, " resp_way"}, int'(resp_way), ew);
    chk(resp_evict === ev, {tag, " resp_evict"}, int'(resp_evict), int'(ev));
    chk(resp_victim_tid === evt, {tag, " resp_victim_tid"}, int'(resp_victim_tid), int'(evt));
    chk(set_valid_o === xv, "R1 set_valid_o", int'(set_valid_o), int'(xv));
    chk(set_owner_o === xo, "R1 set_owner_o", int'(set_owner_o), int'(xo));
    if (!hit) begin
      chk(cnt(s, tid) <= cap, "R6 occupancy cap", cnt(s, tid), cap);
      if (!solo_mode && yeff == WAYS / 2)
        chk(!(ev && evt != tid), "R7 other thread evicted", int'(evt), int'(tid));
    end
  endtask

  task automatic restart(int y, bit solo);
    @(negedge clk);
    rst_n = 0; resv_deg = CW'(y); solo_mode = solo;
    model_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic random_phase(int y, bit solo, int n);
    restart(y, solo);
    for (int k = 0; k < n; k++)
      do_req(($urandom % 4) == 0, 1'($urandom % 2), int'($urandom % SETS), int'($urandom % WAYS));
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    repeat (2) @(negedge clk);
    // R11: reset state
    chk(resp_valid === 1'b0 && resp_evict === 1'b0, "R11 resp after reset", int'(resp_valid), 0);
    chk(set_valid_o === '0 && set_owner_o === '0, "R11 set outputs after reset", int'(set_valid_o), 0);
    rst_n = 1;

    // R9: hit on invalid way changes nothing
    do_req(1, 1, 3, 5);
    chk(set_valid_o === '0 && resp_evict === 1'b0, "R9 hit on invalid way", int'(set_valid_o), 0);

    // R8: recency after a refresh, no reservation
    restart(0, 0);
    for (int i = 0; i < WAYS; i++) do_req(0, 0, 1, 0);
    do_req(1, 0, 1, 0);
    do_req(0, 0, 1, 0);
    chk(int'(resp_way) == 1, "R8 LRU after refresh", int'(resp_way), 1);

    // R2: degree 9 clamps to 4; fifth fill of a thread must self-evict
    restart(9, 0);
    for (int i = 0; i < 4; i++) do_req(0, 1, 2, 0);
    do_req(0, 1, 2, 0);
    chk(resp_evict === 1'b1 && int'(resp_way) == 0, "R2 clamp to half", int'(resp_way), 0);

    // R10: single-thread mode lets thread 1 take thread 0's LRU line
    restart(3, 1);
    for (int i = 0; i < WAYS; i++) do_req(0, 0, 0, 0);
    do_req(0, 1, 0, 0);
    chk(resp_evict === 1'b1 && resp_victim_tid === 1'b0 && int'(resp_way) == 0,
        "R10 solo takes any way", int'(resp_way), 0);

    // R5: at cap with free ways, Y=2
    restart(2, 0);
    for (int i = 0; i < 6; i++) do_req(0, 0, 1, 0);
    do_req(0, 0, 1, 0);
    chk(resp_evict === 1'b1 && int'(resp_way) == 0, "R5 at cap self-evicts", int'(resp_way), 0);

    for (int y = 0; y <= 4; y++) random_phase(y, 0, 600);
    random_phase(6, 0, 400);
    random_phase(2, 1, 400);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule